// File: doc/BRIEF.md
# PWM Dimming Duty-to-Reference Converter

This block serves the PWM dimming mode of an LED boost driver. It watches the synchronized, logic-level control pin and measures the duty cycle of each PWM period from one rising edge to the next. It counts the clock cycles the pin spends high and the total cycles in the period. It then scales a full-scale reference code by that ratio. The full-scale code stands for the 200 mV feedback target. The result passes through a first-order smoothing filter, so the LED current follows a steady level instead of a pulse train. Because only the timing of the pin is used, the result does not depend on the pin's high voltage level.

When the pin stops toggling for longer than a timeout, the output is set directly to full scale (pin held high) or to zero (pin held low). The timeout is longer than the slowest supported PWM period. Clearing the mode-enable input discards all state. The first complete period after enabling gives the first valid code.

Top module: `pwm_dim_ref`

## Requirements
- R1: After a full period (rising edge to rising edge) of H high cycles out of T total cycles, the settled `ref_code` equals floor(FULL_SCALE*H/T). FULL_SCALE defaults to 1000, which represents the 200 mV target.
- R2: R1 holds for every period length between CLK_HZ/100000 and CLK_HZ/20000 cycles, which covers 100 kHz down to 20 kHz.
- R3: A 1% duty cycle is resolved at both ends of the frequency range. With the defaults this settles to code 10 at 100 kHz and at 20 kHz.
- R4: When the duty cycle changes, `ref_code` changes only once every FILT_STEP_DIV cycles (or when a new result arrives). Each step is at most (FULL_SCALE>>FILT_SHIFT)+1 codes, values strictly between the old and new codes appear on the way, and the code settles exactly on the new value.
- R5: If the pin stays high with no edge for TIMEOUT_CYC cycles, `ref_code` jumps directly to FULL_SCALE. It does not change because of the timeout during the first TIMEOUT_CYC cycles after the last edge.
- R6: If the pin stays low with no edge for TIMEOUT_CYC cycles, `ref_code` jumps directly to 0. The first TIMEOUT_CYC cycles after the last edge behave the same way as in R5.
- R7: `ref_code` never exceeds FULL_SCALE.
- R8: During reset, and one cycle after `dim_en` goes low, `ref_valid` is 0 and `ref_code` is 0. Any period being measured is discarded.
- R9: After enabling, the first rising edge only starts a measurement and produces no output. `ref_valid` rises with the first result, which is applied to `ref_code` without filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_sync | input | 1 | Control pin, already synchronized to clk |
| dim_en | input | 1 | PWM dimming mode active; low clears all state |
| ref_code | output | REF_W | Filtered reference code, FULL_SCALE = full target |
| ref_valid | output | 1 | A measured or forced reference is present |

## Verification
The bench builds the block with its default parameters. These are a 50 MHz clock, 16-bit counters, a 10-bit code with FULL_SCALE 1000, a 3000-cycle timeout, a filter shift of 4 and a filter step every 8 cycles. With these values, the 500-cycle (100 kHz) and 2500-cycle (20 kHz) periods give exact floor results that the bench can compute, including the 1% cases that map to code 10. The filter settles within a few PWM periods, so the bench can confirm both the bounded intermediate steps and the exact final value. A 3000-cycle timeout also lets the bench sample just before and just after the forced change without long runs.

// File: rtl/pwmref_pkg.sv
package pwmref_pkg;

   // Sequencer state of the iterative quotient unit
   typedef enum logic {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;

   // Choice of quotient implementation
   typedef enum int {
      DIV_ITERATIVE   = 0,
      DIV_SINGLE_STEP = 1
   } div_kind_e;

endpackage

// File: rtl/pwm_period_meter.sv
module pwm_period_meter #(
   parameter int CNT_W       = 16,
   parameter int TIMEOUT_CYC = 3000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pin,
   output logic             smp_valid,
   output logic [CNT_W-1:0] smp_high,
   output logic [CNT_W-1:0] smp_total,
   output logic             smp_direct
);

   localparam logic [CNT_W-1:0] CNT_MAX   = '1;
   localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(TIMEOUT_CYC - 1);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   logic             pin_q;
   logic             armed;
   logic             idle_fired;
   logic [CNT_W-1:0] per_cnt;
   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W-1:0] idle_cnt;
   logic             rise;
   logic             any_edge;

   assign rise     = pin & ~pin_q;
   assign any_edge = pin ^ pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q      <= 1'b0;
         armed      <= 1'b0;
         idle_fired <= 1'b0;
         per_cnt    <= '0;
         hi_cnt     <= '0;
         idle_cnt   <= '0;
         smp_valid  <= 1'b0;
         smp_high   <= '0;
         smp_total  <= '0;
         smp_direct <= 1'b0;
      end else if (!en) begin
         pin_q      <= 1'b0;
         armed      <= 1'b0;
         idle_fired <= 1'b0;
         per_cnt    <= '0;
         hi_cnt     <= '0;
         idle_cnt   <= '0;
         smp_valid  <= 1'b0;
         smp_high   <= '0;
         smp_total  <= '0;
         smp_direct <= 1'b0;
      end else begin
         pin_q     <= pin;
         smp_valid <= 1'b0;

         // static-level watchdog
         if (any_edge) begin
            idle_cnt   <= '0;
            idle_fired <= 1'b0;
         end else if (!idle_fired) begin
            if (idle_cnt == IDLE_LAST) begin
               idle_fired <= 1'b1;
               armed      <= 1'b0;
               smp_valid  <= 1'b1;
               smp_direct <= 1'b1;
               smp_high   <= pin ? ONE : '0;
               smp_total  <= ONE;
            end else begin
               idle_cnt <= idle_cnt + ONE;
            end
         end

         // period measurement, rising edge to rising edge
         if (rise) begin
            if (armed) begin
               smp_valid  <= 1'b1;
               smp_direct <= 1'b0;
               smp_high   <= hi_cnt;
               smp_total  <= per_cnt;
            end
            armed   <= 1'b1;
            per_cnt <= ONE;
            hi_cnt  <= ONE;
         end else begin
            if (per_cnt != CNT_MAX) per_cnt <= per_cnt + ONE;
            if (pin && hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + ONE;
         end
      end
   end

endmodule

// File: rtl/ref_divider.sv
module ref_divider
   import pwmref_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int REF_W      = 10,
   parameter int FULL_SCALE = 1000,
   parameter int DIV_KIND   = DIV_ITERATIVE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             in_valid,
   input  logic [CNT_W-1:0] in_high,
   input  logic [CNT_W-1:0] in_total,
   input  logic             in_direct,
   output logic             out_valid,
   output logic [REF_W-1:0] out_code,
   output logic             out_direct
);

   localparam int NW = CNT_W + REF_W;
   localparam int BW = $clog2(NW + 1);

   logic [NW-1:0] num_in;
   assign num_in = NW'(in_high) * NW'(FULL_SCALE);

   function automatic logic [REF_W-1:0] clamp_q(input logic [NW-1:0] q);
      if (q > NW'(FULL_SCALE)) return REF_W'(FULL_SCALE);
      return q[REF_W-1:0];
   endfunction

   generate
      if (DIV_KIND == DIV_SINGLE_STEP) begin : g_single
         logic [NW-1:0] quo_c;
         assign quo_c = (in_total == '0) ? '1 : (num_in / NW'(in_total));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid  <= 1'b0;
               out_code   <= '0;
               out_direct <= 1'b0;
            end else if (!en) begin
               out_valid  <= 1'b0;
               out_code   <= '0;
               out_direct <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_code   <= clamp_q(quo_c);
                  out_direct <= in_direct;
               end
            end
         end
      end else begin : g_iter
         div_state_e       st;
         logic [NW-1:0]    num_sh;
         logic [NW-1:0]    quo;
         logic [CNT_W-1:0] den;
         logic [CNT_W-1:0] rem;
         logic [BW-1:0]    bits_left;
         logic             dir_q;
         logic [CNT_W:0]   rem_try;
         logic [CNT_W:0]   rem_sub;
         logic             take;

         assign rem_try = {rem, num_sh[NW-1]};
         assign take    = rem_try >= {1'b0, den};
         assign rem_sub = rem_try - {1'b0, den};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st         <= DIV_IDLE;
               num_sh     <= '0;
               quo        <= '0;
               den        <= '0;
               rem        <= '0;
               bits_left  <= '0;
               dir_q      <= 1'b0;
               out_valid  <= 1'b0;
               out_code   <= '0;
               out_direct <= 1'b0;
            end else if (!en) begin
               st         <= DIV_IDLE;
               num_sh     <= '0;
               quo        <= '0;
               den        <= '0;
               rem        <= '0;
               bits_left  <= '0;
               dir_q      <= 1'b0;
               out_valid  <= 1'b0;
               out_code   <= '0;
               out_direct <= 1'b0;
            end else begin
               out_valid <= 1'b0;
               case (st)
                  DIV_IDLE: begin
                     if (in_valid) begin
                        num_sh    <= num_in;
                        den       <= in_total;
                        rem       <= '0;
                        quo       <= '0;
                        bits_left <= BW'(NW);
                        dir_q     <= in_direct;
                        st        <= DIV_RUN;
                     end
                  end
                  default: begin
                     rem    <= take ? rem_sub[CNT_W-1:0] : rem_try[CNT_W-1:0];
                     quo    <= {quo[NW-2:0], take};
                     num_sh <= num_sh << 1;
                     if (bits_left == BW'(1)) begin
                        out_valid  <= 1'b1;
                        out_code   <= clamp_q({quo[NW-2:0], take});
                        out_direct <= dir_q;
                        st         <= DIV_IDLE;
                     end else begin
                        bits_left <= bits_left - BW'(1);
                     end
                  end
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ref_iir_smoother.sv
module ref_iir_smoother #(
   parameter int REF_W      = 10,
   parameter int FULL_SCALE = 1000,
   parameter int SHIFT      = 4,
   parameter int STEP_DIV   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             in_valid,
   input  logic [REF_W-1:0] in_code,
   input  logic             in_load,
   output logic [REF_W-1:0] out_code,
   output logic             out_valid,
   output logic             step_tick
);

   localparam int AW = REF_W + SHIFT + 2;

   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] tgt;
   logic signed [AW-1:0] diff;
   logic signed [AW-1:0] step;
   logic signed [AW-1:0] in_ext;
   logic signed [AW-1:0] acc_out;

   assign in_ext  = $signed({{(AW - REF_W){1'b0}}, in_code}) <<< SHIFT;
   assign diff    = tgt - acc;
   assign acc_out = acc >>> SHIFT;

   generate
      if (STEP_DIV <= 1) begin : g_tick_every
         assign step_tick = 1'b1;
      end else begin : g_tick_div
         localparam int DW = $clog2(STEP_DIV);
         logic [DW-1:0] div_cnt;
         assign step_tick = (div_cnt == DW'(STEP_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         div_cnt <= '0;
            else if (!en)       div_cnt <= '0;
            else if (step_tick) div_cnt <= '0;
            else                div_cnt <= div_cnt + DW'(1);
         end
      end

      if (SHIFT == 0) begin : g_no_filter
         assign step = diff;
      end else begin : g_shift_filter
         logic signed [AW-1:0] step_raw;
         assign step_raw = diff >>> SHIFT;
         // a minimum unit step keeps the loop from stalling short of target
         assign step = (step_raw == '0 && diff != '0)
                     ? (diff[AW-1] ? '1 : AW'(1))
                     : step_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         tgt       <= '0;
         out_valid <= 1'b0;
      end else if (!en) begin
         acc       <= '0;
         tgt       <= '0;
         out_valid <= 1'b0;
      end else if (in_valid) begin
         tgt       <= in_ext;
         out_valid <= 1'b1;
         if (in_load || !out_valid) acc <= in_ext;
      end else if (step_tick && out_valid) begin
         acc <= acc + step;
      end
   end

   always_comb begin
      if (acc_out > AW'(FULL_SCALE))  out_code = REF_W'(FULL_SCALE);
      else if (acc_out < 0)           out_code = '0;
      else                            out_code = acc_out[REF_W-1:0];
   end

endmodule

// File: rtl/pwm_dim_ref.sv
module pwm_dim_ref
   import pwmref_pkg::*;
#(
   parameter int CLK_HZ        = 50_000_000,
   parameter int CNT_W         = 16,
   parameter int REF_W         = 10,
   parameter int FULL_SCALE    = 1000,
   parameter int TIMEOUT_CYC   = 3000,
   parameter int FILT_SHIFT    = 4,
   parameter int FILT_STEP_DIV = 8,
   parameter int DIV_KIND      = DIV_ITERATIVE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_sync,
   input  logic             dim_en,
   output logic [REF_W-1:0] ref_code,
   output logic             ref_valid
);

   localparam int MIN_PER = CLK_HZ / 100_000;
   localparam int MAX_PER = CLK_HZ / 20_000;

   generate
      if (MIN_PER < 256) begin : g_err_resolution
         $error("clock too slow for 1/256 duty resolution at the fastest rate");
      end
      if (TIMEOUT_CYC <= MAX_PER) begin : g_err_timeout
         $error("timeout must exceed the slowest PWM period");
      end
      if (TIMEOUT_CYC >= (2 ** CNT_W)) begin : g_err_cnt
         $error("counter width too small for timeout");
      end
      if (FULL_SCALE < 256 || FULL_SCALE >= (2 ** REF_W)) begin : g_err_full
         $error("full-scale code out of range for code width");
      end
      if (FILT_SHIFT < 0 || FILT_SHIFT > 12) begin : g_err_shift
         $error("filter shift out of range");
      end
   endgenerate

   logic             smp_valid;
   logic [CNT_W-1:0] smp_high;
   logic [CNT_W-1:0] smp_total;
   logic             smp_direct;
   logic             res_valid;
   logic [REF_W-1:0] res_code;
   logic             res_direct;
   logic             step_tick;

   pwm_period_meter #(
      .CNT_W      (CNT_W),
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (dim_en),
      .pin       (ctrl_sync),
      .smp_valid (smp_valid),
      .smp_high  (smp_high),
      .smp_total (smp_total),
      .smp_direct(smp_direct)
   );

   ref_divider #(
      .CNT_W     (CNT_W),
      .REF_W     (REF_W),
      .FULL_SCALE(FULL_SCALE),
      .DIV_KIND  (DIV_KIND)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (dim_en),
      .in_valid  (smp_valid),
      .in_high   (smp_high),
      .in_total  (smp_total),
      .in_direct (smp_direct),
      .out_valid (res_valid),
      .out_code  (res_code),
      .out_direct(res_direct)
   );

   ref_iir_smoother #(
      .REF_W     (REF_W),
      .FULL_SCALE(FULL_SCALE),
      .SHIFT     (FILT_SHIFT),
      .STEP_DIV  (FILT_STEP_DIV)
   ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (dim_en),
      .in_valid (res_valid),
      .in_code  (res_code),
      .in_load  (res_direct),
      .out_code (ref_code),
      .out_valid(ref_valid),
      .step_tick(step_tick)
   );

endmodule

// File: rtl/pwm_dim_ref_chk.sv
module pwm_dim_ref_chk #(
   parameter int REF_W      = 10,
   parameter int FULL_SCALE = 1000,
   parameter int FILT_SHIFT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dim_en,
   input logic [REF_W-1:0] ref_code,
   input logic             ref_valid,
   input logic             res_valid,
   input logic             step_tick
);

   localparam int MAX_SLEW = (FULL_SCALE >> FILT_SHIFT) + 1;

   // R7
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_code <= REF_W'(FULL_SCALE));

   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dim_en |=> (!ref_valid && ref_code == '0));

   // R4
   slew_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_valid && $past(ref_valid) && !$past(res_valid)) |->
      (((ref_code >= $past(ref_code)) ? (ref_code - $past(ref_code))
                                      : ($past(ref_code) - ref_code))
       <= REF_W'(MAX_SLEW)));

   // R4
   hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_valid && $past(ref_valid) && !$past(step_tick) && !$past(res_valid))
      |-> $stable(ref_code));

   // R9
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_valid) |-> $past(res_valid));

endmodule

bind pwm_dim_ref pwm_dim_ref_chk #(
   .REF_W     (REF_W),
   .FULL_SCALE(FULL_SCALE),
   .FILT_SHIFT(FILT_SHIFT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dim_en   (dim_en),
   .ref_code (ref_code),
   .ref_valid(ref_valid),
   .res_valid(res_valid),
   .step_tick(step_tick)
);

// File: tb/sim_pwm_dim_ref.sv
module sim_pwm_dim_ref;

   localparam int FULL = 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_sync = 1'b0;
   logic       dim_en = 1'b0;
   logic [9:0] ref_code;
   logic       ref_valid;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;
   bit  mon_en = 1'b0;
   int  max_jump = 0;
   bit  seen_mid = 1'b0;
   int  range_bad = 0;
   int  prev_code = 0;

   always #10 clk = ~clk;

   pwm_dim_ref u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_sync(ctrl_sync),
      .dim_en   (dim_en),
      .ref_code (ref_code),
      .ref_valid(ref_valid)
   );

   always @(negedge clk) begin
      if (int'(ref_code) > FULL) range_bad++;
      if (mon_en && ref_valid) begin
         int d;
         d = int'(ref_code) - prev_code;
         if (d < 0) d = -d;
         if (d > max_jump) max_jump = d;
         if (ref_code > 500 && ref_code < 900) seen_mid = 1'b1;
      end
      prev_code = int'(ref_code);
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic one_period(input int h, input int t);
      for (int c = 0; c < t; c++) begin
         ctrl_sync = (c < h);
         @(negedge clk);
      end
   endtask

   task automatic run_steady(input string req, input int h, input int t, input int n);
      repeat (n) one_period(h, t);
      check(req, int'(ref_code), (FULL * h) / t);
      check({req, " valid"}, int'(ref_valid), 1);
   endtask

   task automatic test_reset();
      rst_n = 1'b0; dim_en = 1'b0; ctrl_sync = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 reset valid", int'(ref_valid), 0);
      check("R8 reset code", int'(ref_code), 0);
      dim_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic test_step();
      max_jump = 0; seen_mid = 1'b0; mon_en = 1'b1;
      repeat (8) one_period(450, 500);
      mon_en = 1'b0;
      check("R4 step bounded", int'(max_jump <= (FULL >> 4) + 1), 1);
      check("R4 intermediate seen", int'(seen_mid), 1);
      check("R4 settled", int'(ref_code), 900);
   endtask

   task automatic test_static_high();
      ctrl_sync = 1'b1;
      repeat (2900) @(negedge clk);
      check("R5 before timeout", int'(ref_code), 900);
      repeat (200) @(negedge clk);
      check("R5 forced full", int'(ref_code), FULL);
   endtask

   task automatic test_static_low();
      ctrl_sync = 1'b0;
      repeat (2900) @(negedge clk);
      check("R6 before timeout", int'(ref_code), FULL);
      repeat (200) @(negedge clk);
      check("R6 forced zero", int'(ref_code), 0);
   endtask

   task automatic test_disable();
      repeat (3) one_period(250, 500);
      dim_en = 1'b0;
      @(negedge clk);
      check("R8 disable valid", int'(ref_valid), 0);
      check("R8 disable code", int'(ref_code), 0);
   endtask

   task automatic test_first_result();
      ctrl_sync = 1'b0;
      repeat (4) @(negedge clk);
      dim_en = 1'b1;
      repeat (20) @(negedge clk);
      one_period(150, 500);
      check("R9 no result after first edge", int'(ref_valid), 0);
      ctrl_sync = 1'b1;
      repeat (40) @(negedge clk);
      check("R9 first result valid", int'(ref_valid), 1);
      check("R9 first result unfiltered", int'(ref_code), 300);
   endtask

   initial begin
      @(negedge clk);
      test_reset();
      run_steady("R1 half duty 100k", 250, 500, 10);
      run_steady("R3 one percent 100k", 5, 500, 10);
      run_steady("R1 odd ratio 100k", 333, 500, 10);
      run_steady("R2 37 percent 20k", 925, 2500, 4);
      run_steady("R3 one percent 20k", 25, 2500, 4);
      run_steady("R2 half duty 100k", 250, 500, 10);
      test_step();
      test_static_high();
      test_static_low();
      test_disable();
      test_first_result();
      check("R7 code range", range_bad, 0);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule